// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status

This block is the arithmetic and logic engine of a small 8-bit processor datapath. It holds an accumulator register and a five-bit status register. On each clock edge where the strobe is high, it applies the selected operation. The operation combines the accumulator, an external operand and the stored carry, and writes the new accumulator value and status flags. The new values are computed combinationally from the current registers and inputs. They are only committed on the strobed clock edge.

The supported operations are:
- Add and subtract, each with or without the stored carry or borrow.
- Bitwise AND, XOR and OR.
- Compare, which updates only the flags.
- Four accumulator rotates.
- Invert the accumulator.
- Invert the carry, and force the carry to one.

A separate unit counts the operand up or down by one, for whatever register the surrounding datapath chooses. Its result appears on a combinational output. Its flags go into the status register when that operation is strobed. The datapath writes the stepped value back on its own side.

Top module: `acc_alu_core`

## Requirements
- R1: While reset is low, the accumulator and every status bit are 0. They stay at 0 until the first strobed operation.
- R2: The status port layout is bit 4 S, bit 3 Z, bit 2 AC, bit 1 P, bit 0 CY. Op code 0 (ADD) writes acc+operand, and op code 1 (ADC) writes acc+operand+CY, both modulo 256. The flags come from the sum, and CY is the carry out of bit 7.
- R3: Op code 2 (SUB) writes acc−operand, and op code 3 (SBB) writes acc−operand−CY, both modulo 256 in two's complement. CY is set exactly when operand plus borrow-in exceeds acc as unsigned numbers.
- R4: For add, subtract, the bitwise ops, increment and decrement, the flags are defined as follows. S is bit 7 of the result, and Z is set when the result is 00h. P is set when the result has an even count of ones. For add, AC is set on a carry from bit 3 into bit 4. For subtract and compare, AC is set when acc[3:0] ≥ operand[3:0] + borrow-in. Adding 99h to 88h gives 21h with status 00111b.
- R5: Op code 7 (compare) sets S, Z, AC, P and CY exactly as SUB would, and leaves the accumulator unchanged.
- R6: Op codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and set S, Z and P from it. They clear CY and keep AC.
- R7: Op code 8 rotates left circular, with the old bit 7 going to bit 0 and to CY. Op code 9 rotates right circular, with the old bit 0 going to bit 7 and to CY. Other flags are kept.
- R8: Op code 10 rotates left through carry (old CY to bit 0, old bit 7 to CY). Op code 11 rotates right through carry (old CY to bit 7, old bit 0 to CY). Other flags are kept.
- R9: Op code 12 inverts the accumulator and keeps all flags. Op code 13 inverts CY, and op code 14 sets CY to 1. Both of these keep the accumulator and the other four flags.
- R10: step_out is operand−1 when op code is 16 (DEC), and operand+1 otherwise, modulo 256, combinationally. Strobing op code 15 (INC) or 16 sets S, Z and P from step_out. INC sets AC when operand[3:0] is Fh, and DEC sets AC when operand[3:0] is nonzero. The strobe keeps CY and the accumulator.
- R11: With strobe low, or with an op code from 17 to 31, the accumulator and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Commit the selected operation on this edge |
| op_code | input | 5 | Operation select (codes in R2–R11) |
| operand | input | 8 | Second operand, or value to be stepped |
| acc | output | 8 | Accumulator register |
| flags | output | 5 | Status register {S,Z,AC,P,CY} |
| step_out | output | 8 | Combinational increment/decrement result |

## Verification
Within one strobed cycle, the step unit produces its value on step_out while the status register takes that value's flags. In the same cycle, the accumulator must hold and the carry must survive. The bench strobes increments and decrements on operands such as FFh, 0Fh and 00h, with the carry both set and clear beforehand. It checks step_out combinationally in the driving cycle. It then checks the accumulator and flags from the scoreboard after the edge. A long mixed stream also puts rotates through carry right after increments and decrements. This shows that the carry preserved by one operation is the carry consumed by the next.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    // status bit positions
    localparam int FL_CY = 0;
    localparam int FL_P  = 1;
    localparam int FL_AC = 2;
    localparam int FL_Z  = 3;
    localparam int FL_S  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_RLC = 5'd8,
        OP_RRC = 5'd9,
        OP_RAL = 5'd10,
        OP_RAR = 5'd11,
        OP_CMA = 5'd12,
        OP_CMC = 5'd13,
        OP_STC = 5'd14,
        OP_INC = 5'd15,
        OP_DEC = 5'd16
    } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin_en,
    input  logic         cy_in,
    output logic [W-1:0] sum,
    output logic         cy_out,
    output logic         hc_out
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   full;
    logic [H:0]   low;

    always_comb begin
        b_eff  = sub ? ~b : b;
        cin    = sub ? ~(cin_en & cy_in) : (cin_en & cy_in);
        full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        low    = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        sum    = full[W-1:0];
        // subtract reports borrow: inverse of the internal carry
        cy_out = sub ? ~full[W] : full[W];
        hc_out = low[H];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    always_comb begin
        res    = a;
        cy_out = cy_in;
        case (op)
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            OP_CMA: res = ~a;
            OP_RLC: begin
                res    = {a[W-2:0], a[W-1]};
                cy_out = a[W-1];
            end
            OP_RRC: begin
                res    = {a[0], a[W-1:1]};
                cy_out = a[0];
            end
            OP_RAL: begin
                res    = {a[W-2:0], cy_in};
                cy_out = a[W-1];
            end
            OP_RAR: begin
                res    = {cy_in, a[W-1:1]};
                cy_out = a[0];
            end
            default: begin
                res    = a;
                cy_out = cy_in;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] res,
    output logic         hc_out
);
    localparam int H = W / 2;
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        res    = down ? (a - ONE) : (a + ONE);
        hc_out = down ? (|a[H-1:0]) : (&a[H-1:0]);
    end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status #(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    output logic         sign,
    output logic         zero,
    output logic         par_even
);
    logic [W-1:0] chain;

    assign chain[0] = res[0];
    generate
        for (genvar i = 1; i < W; i++) begin : g_par
            assign chain[i] = chain[i-1] ^ res[i];
        end
    endgenerate

    assign sign     = res[W-1];
    assign zero     = (res == '0);
    assign par_even = ~chain[W-1];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [OP_W-1:0]     op_code,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   acc,
    output logic [FLAG_W-1:0]   flags,
    output logic [DATA_W-1:0]   step_out
);
    alu_op_e             op;
    logic [DATA_W-1:0]   acc_q, acc_d;
    logic [FLAG_W-1:0]   fl_q, fl_d;

    logic                is_sub, use_cin;
    logic [DATA_W-1:0]   ar_sum;
    logic                ar_cy, ar_hc;
    logic [DATA_W-1:0]   lg_res;
    logic                lg_cy;
    logic [DATA_W-1:0]   sp_res;
    logic                sp_hc;
    logic                ar_s, ar_z, ar_p;
    logic                lg_s, lg_z, lg_p;
    logic                sp_s, sp_z, sp_p;

    assign op = alu_op_e'(op_code);

    always_comb begin
        is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        use_cin = (op == OP_ADC) || (op == OP_SBB);
    end

    acc_alu_addsub #(.W(DATA_W)) u_arith (
        .a      (acc_q),
        .b      (operand),
        .sub    (is_sub),
        .cin_en (use_cin),
        .cy_in  (fl_q[FL_CY]),
        .sum    (ar_sum),
        .cy_out (ar_cy),
        .hc_out (ar_hc)
    );

    acc_alu_bitops #(.W(DATA_W)) u_bits (
        .a      (acc_q),
        .b      (operand),
        .op     (op),
        .cy_in  (fl_q[FL_CY]),
        .res    (lg_res),
        .cy_out (lg_cy)
    );

    acc_alu_step #(.W(DATA_W)) u_step (
        .a      (operand),
        .down   (op == OP_DEC),
        .res    (sp_res),
        .hc_out (sp_hc)
    );

    acc_alu_status #(.W(DATA_W)) u_st_ar (
        .res(ar_sum), .sign(ar_s), .zero(ar_z), .par_even(ar_p)
    );
    acc_alu_status #(.W(DATA_W)) u_st_lg (
        .res(lg_res), .sign(lg_s), .zero(lg_z), .par_even(lg_p)
    );
    acc_alu_status #(.W(DATA_W)) u_st_sp (
        .res(sp_res), .sign(sp_s), .zero(sp_z), .par_even(sp_p)
    );

    // next-value selection
    always_comb begin
        acc_d = acc_q;
        fl_d  = fl_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                if (op != OP_CMP) begin
                    acc_d = ar_sum;
                end
                fl_d[FL_S]  = ar_s;
                fl_d[FL_Z]  = ar_z;
                fl_d[FL_AC] = ar_hc;
                fl_d[FL_P]  = ar_p;
                fl_d[FL_CY] = ar_cy;
            end
            OP_AND, OP_XOR, OP_OR: begin
                acc_d       = lg_res;
                fl_d[FL_S]  = lg_s;
                fl_d[FL_Z]  = lg_z;
                fl_d[FL_P]  = lg_p;
                fl_d[FL_CY] = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                acc_d       = lg_res;
                fl_d[FL_CY] = lg_cy;
            end
            OP_CMA: acc_d = lg_res;
            OP_CMC: fl_d[FL_CY] = ~fl_q[FL_CY];
            OP_STC: fl_d[FL_CY] = 1'b1;
            OP_INC, OP_DEC: begin
                fl_d[FL_S]  = sp_s;
                fl_d[FL_Z]  = sp_z;
                fl_d[FL_AC] = sp_hc;
                fl_d[FL_P]  = sp_p;
            end
            default: begin
                acc_d = acc_q;
                fl_d  = fl_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            fl_q  <= '0;
        end else if (strobe) begin
            acc_q <= acc_d;
            fl_q  <= fl_d;
        end
    end

    assign acc      = acc_q;
    assign flags    = fl_q;
    assign step_out = sp_res;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc,
    input logic [4:0]        flags,
    input logic [DATA_W-1:0] step_out
);
    logic unused_in;
    assign unused_in = ^{operand, step_out};

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe || op_code > 5'd16) |=> ($stable(acc) && $stable(flags)));

    assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_code == 5'd7) |=> $stable(acc));

    assert_bitwise_clears_cy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_code >= 5'd4 && op_code <= 5'd6) |=> !flags[0]);

    assert_stc_sets_cy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_code == 5'd14) |=> (flags[0] && $stable(acc)));

    assert_cma_inverts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_code == 5'd12) |=> (acc == ~$past(acc) && $stable(flags)));

    assert_step_keeps_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (op_code == 5'd15 || op_code == 5'd16))
        |=> ($stable(acc) && flags[0] == $past(flags[0])));

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op_code <= 5'd6) |=> (flags[3] == (acc == '0)));
endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .op_code  (op_code),
    .operand  (operand),
    .acc      (acc),
    .flags    (flags),
    .step_out (step_out)
);

// File: tb/tb_acc_alu_core.sv
`timescale 1ns/100ps
module tb_acc_alu_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       strobe;
    logic [4:0] op_code;
    logic [7:0] operand;
    logic [7:0] acc;
    logic [4:0] flags;
    logic [7:0] step_out;

    always #2.5 clk = ~clk;

    acc_alu_core dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op_code(op_code),
        .operand(operand), .acc(acc), .flags(flags), .step_out(step_out)
    );

    typedef struct packed {
        logic [7:0] acc;
        logic [4:0] fl;
        logic [4:0] op;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 0;
    logic       seen = 1'b0;
    logic [7:0] m_acc;
    logic [4:0] m_fl;

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:             return "R2";
            5'd2, 5'd3:             return "R3";
            5'd4, 5'd5, 5'd6:       return "R6";
            5'd7:                   return "R5";
            5'd8, 5'd9:             return "R7";
            5'd10, 5'd11:           return "R8";
            5'd12, 5'd13, 5'd14:    return "R9";
            5'd15, 5'd16:           return "R10";
            default:                return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic predict(input logic [4:0] op, input logic [7:0] b,
                           output logic [7:0] na, output logic [4:0] nf,
                           output logic [7:0] st);
        int a, bi, c, t, br;
        logic [7:0] r;
        a  = int'(m_acc);
        bi = int'(b);
        c  = int'(m_fl[0]);
        na = m_acc;
        nf = m_fl;
        st = (op == 5'd16) ? 8'((bi + 255) % 256) : 8'((bi + 1) % 256);
        case (op)
            5'd0, 5'd1: begin
                br = (op == 5'd1) ? c : 0;
                t  = a + bi + br;
                r  = 8'(t);
                na = r;
                nf = {r[7], r == 8'h00, ((a % 16) + (bi % 16) + br) > 15,
                      ($countones(r) % 2) == 0, t > 255};
            end
            5'd2, 5'd3, 5'd7: begin
                br = (op == 5'd3) ? c : 0;
                t  = a - bi - br;
                r  = 8'(t);
                if (op != 5'd7) na = r;
                nf = {r[7], r == 8'h00, (a % 16) >= ((bi % 16) + br),
                      ($countones(r) % 2) == 0, t < 0};
            end
            5'd4, 5'd5, 5'd6: begin
                r  = (op == 5'd4) ? (m_acc & b) : (op == 5'd5) ? (m_acc ^ b) : (m_acc | b);
                na = r;
                nf = {r[7], r == 8'h00, m_fl[2], ($countones(r) % 2) == 0, 1'b0};
            end
            5'd8:  begin na = {m_acc[6:0], m_acc[7]}; nf[0] = m_acc[7]; end
            5'd9:  begin na = {m_acc[0], m_acc[7:1]}; nf[0] = m_acc[0]; end
            5'd10: begin na = {m_acc[6:0], m_fl[0]};  nf[0] = m_acc[7]; end
            5'd11: begin na = {m_fl[0], m_acc[7:1]};  nf[0] = m_acc[0]; end
            5'd12: na = ~m_acc;
            5'd13: nf[0] = ~m_fl[0];
            5'd14: nf[0] = 1'b1;
            5'd15, 5'd16: begin
                r  = st;
                nf = {r[7], r == 8'h00,
                      (op == 5'd15) ? ((bi % 16) == 15) : ((bi % 16) != 0),
                      ($countones(r) % 2) == 0, m_fl[0]};
            end
            default: ;
        endcase
    endtask

    // driver: one strobed operation per call
    task automatic run_op(input logic [4:0] op, input logic [7:0] b);
        logic [7:0] na, st;
        logic [4:0] nf;
        exp_t e;
        @(negedge clk);
        op_code = op;
        operand = b;
        strobe  = 1'b1;
        predict(op, b, na, nf, st);
        e.acc = na;
        e.fl  = nf;
        e.op  = op;
        sb_q.push_back(e);
        m_acc = na;
        m_fl  = nf;
        #1;
        check("R10", "step_out", step_out, st);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        strobe = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare registered results after each strobed edge
    always @(posedge clk) seen <= strobe && rst_n;

    always @(negedge clk) begin
        if (seen) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R11 scoreboard empty actual=%0h expected=none", acc);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(req_of(e.op), "acc", acc, e.acc);
                check(req_of(e.op), "flags", {3'b0, flags}, {3'b0, e.fl});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst_n   = 1'b0;
        strobe  = 1'b0;
        op_code = 5'd0;
        operand = 8'h00;
        m_acc   = 8'h00;
        m_fl    = 5'h00;
        repeat (3) @(negedge clk);
        check("R1", "acc in reset", acc, 8'h00);
        check("R1", "flags in reset", {3'b0, flags}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "acc after reset", acc, 8'h00);
        check("R1", "flags after reset", {3'b0, flags}, 8'h00);

        // R4 worked example: 88h + 99h
        run_op(5'd0, 8'h88);
        run_op(5'd0, 8'h99);
        idle(1);
        check("R4", "example acc", acc, 8'h21);
        check("R4", "example flags", {3'b0, flags}, 8'h07);

        // R2 add with carry in
        run_op(5'd1, 8'h10);
        run_op(5'd1, 8'hCE);
        run_op(5'd1, 8'h00);
        // R3 subtract and borrow
        run_op(5'd2, 8'h40);
        run_op(5'd3, 8'h01);
        run_op(5'd2, 8'h00);
        run_op(5'd3, 8'hFF);
        // R5 compare equal, less, greater
        run_op(5'd7, m_acc);
        run_op(5'd7, 8'hFF);
        run_op(5'd7, 8'h00);
        // R6 bitwise
        run_op(5'd14, 8'h00);
        run_op(5'd4, 8'h0F);
        run_op(5'd5, 8'hFF);
        run_op(5'd6, 8'h81);
        run_op(5'd4, 8'h00);
        // R7 and R8 rotates with carry in both states
        run_op(5'd6, 8'h81);
        run_op(5'd8, 8'h00);
        run_op(5'd9, 8'h00);
        run_op(5'd14, 8'h00);
        run_op(5'd10, 8'h00);
        run_op(5'd13, 8'h00);
        run_op(5'd11, 8'h00);
        run_op(5'd14, 8'h00);
        run_op(5'd11, 8'h00);
        // R9 invert accumulator and carry
        run_op(5'd12, 8'h00);
        run_op(5'd13, 8'h00);
        run_op(5'd13, 8'h00);
        // R10 step unit with carry set then clear
        run_op(5'd14, 8'h00);
        run_op(5'd15, 8'hFF);
        run_op(5'd15, 8'h0F);
        run_op(5'd16, 8'h00);
        run_op(5'd13, 8'h00);
        run_op(5'd16, 8'h10);
        run_op(5'd16, 8'h01);
        run_op(5'd15, 8'h7F);
        // R11 unused op codes
        run_op(5'd17, 8'h55);
        run_op(5'd31, 8'hAA);

        // mixed stream
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_op(5'(lf[4:0] % 20), lf[15:8]);
        end

        // R11 strobe low: nothing moves
        idle(1);
        @(negedge clk);
        op_code = 5'd12;
        operand = 8'hFF;
        repeat (4) @(negedge clk);
        check("R11", "acc with strobe low", acc, m_acc);
        check("R11", "flags with strobe low", {3'b0, flags}, {3'b0, m_fl});

        // R1 reset again mid-run
        run_op(5'd14, 8'h00);
        run_op(5'd0, 8'h5A);
        idle(2);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "acc on second reset", acc, 8'h00);
        check("R1", "flags on second reset", {3'b0, flags}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule